// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side and uses a chooser table to pick one of them. The first predictor uses global history: a shift register holding the outcomes of the most recent branches indexes a table of two-bit counters. The second predictor uses local history in two levels: instruction address bits select a per-branch history entry, and that history indexes a table of three-bit counters. The chooser is a table of two-bit counters indexed by the global history. It learns which of the two predictors has been more reliable in the current global context.

A lookup is combinational. The fetch address on the lookup port produces the final prediction in the same cycle, together with the two component guesses. When a branch resolves, the update port carries its address and outcome. On the next clock edge the block trains the counters and the chooser, then shifts the outcome into both history registers. An update uses the state as it was before that edge, which is the same state a lookup of that branch would have used. With the default parameters the state is 4K two-bit global counters, 4K two-bit chooser counters, 1K ten-bit local histories and 1K three-bit local counters.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every counter holds its weakly-not-taken value (1 for two-bit counters, 3 for three-bit counters) and every history register is zero. All three prediction outputs are therefore 0 for any address.
- R2: The global prediction is the upper bit of the two-bit global counter selected by the global history register.
- R3: On each update, the global history shifts left by one and takes the outcome into bit 0. Bit i therefore records the outcome of the (i+1)-th most recent update, with 1 meaning taken.
- R4: The local history entry is selected by address bits [LHT_IDX_W+1:2]. On each update, the entry selected by the update address shifts left and takes the outcome into bit 0.
- R5: The local prediction is 1 when the three-bit counter selected by the local history of the lookup address holds 4 or more.
- R6: Every counter counts up on a taken outcome and down on a not-taken outcome. It saturates at 0 and at its maximum (3 for two-bit counters, 7 for three-bit counters).
- R7: The chooser counter is selected by the global history. When its upper bit is 1 the final prediction is the local one, otherwise it is the global one. When the two components agree, the final prediction equals them.
- R8: The chooser counter changes only on an update where the two component predictions differ. It counts up when the local one matched the outcome and down when the global one did.
- R9: An update trains the counters at the indices formed from the histories before that update. A lookup in the same cycle as an update sees the state before the update.
- R10: With upd_valid low, no counter and no history changes. A repeated lookup of the same address returns the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Final taken prediction |
| pred_global | output | 1 | Global-history component prediction |
| pred_local | output | 1 | Local-history component prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
The assertions check on every cycle that the global history shifts the outcome into bit 0 and holds its value when no update is presented. They also check that outputs stay stable when nothing is updated and that the final prediction equals the components whenever the two agree. Counter saturation, the training of the local second level and the chooser's move toward the correct side can only be shown by the bench. It sweeps a small configuration through directed and pseudo-random outcome streams and compares every output against an arithmetic model of the tables.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic {
      PICK_GLOBAL = 1'b0,
      PICK_LOCAL  = 1'b1
   } pick_e;

   // weakly-not-taken start value for an n-bit counter
   function automatic int unsigned weak_nt(input int unsigned w);
      return (1 << (w - 1)) - 1;
   endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int IDX_W = 12,
   parameter int CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             up_en,
   input  logic [IDX_W-1:0] up_idx,
   input  logic             up_inc,
   output logic [CTR_W-1:0] up_ctr
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CMAX  = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CINIT = CTR_W'(tbp_pkg::weak_nt(CTR_W));

   if (CTR_W < 2 || CTR_W > 8) begin : g_bad_ctr
      $error("tbp_ctr_table: CTR_W must be 2..8");
   end

   logic [CTR_W-1:0] cells [DEPTH];
   logic [CTR_W-1:0] nxt;

   assign rd_ctr = cells[rd_idx];
   assign up_ctr = cells[up_idx];

   always_comb begin
      nxt = up_ctr;
      if (up_inc) begin
         if (up_ctr != CMAX) nxt = up_ctr + 1'b1;
      end else begin
         if (up_ctr != '0) nxt = up_ctr - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= CINIT;
      end else if (up_en) begin
         cells[up_idx] <= nxt;
      end
   end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              up_en,
   input  logic [IDX_W-1:0]  up_idx,
   input  logic              up_bit,
   output logic [HIST_W-1:0] up_hist
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 2) begin : g_bad_hist
      $error("tbp_hist_table: HIST_W must be at least 2");
   end

   logic [HIST_W-1:0] hist [DEPTH];

   assign rd_hist = hist[rd_idx];
   assign up_hist = hist[up_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (up_en) begin
         hist[up_idx] <= {up_hist[HIST_W-2:0], up_bit};
      end
   end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
   parameter int PC_W      = 32,
   parameter int GHIST_W   = 12,
   parameter int LHT_IDX_W = 10,
   parameter int LHIST_W   = 10,
   parameter int GCTR_W    = 2,
   parameter int LCTR_W    = 3,
   parameter int SEL_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lookup_pc,
   output logic            pred_taken,
   output logic            pred_global,
   output logic            pred_local,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);
   import tbp_pkg::*;

   localparam int LO_BIT = 2;
   localparam int HI_BIT = LHT_IDX_W + LO_BIT - 1;

   if (HI_BIT >= PC_W) begin : g_bad_pc
      $error("tournament_predictor: PC_W too small for LHT_IDX_W");
   end
   if (GHIST_W < 2) begin : g_bad_ghist
      $error("tournament_predictor: GHIST_W must be at least 2");
   end

   logic [GHIST_W-1:0]   ghr_q;
   logic [LHT_IDX_W-1:0] lk_slot, up_slot;
   logic [LHIST_W-1:0]   lk_lhist, up_lhist;
   logic [GCTR_W-1:0]    g_rd, g_up;
   logic [LCTR_W-1:0]    l_rd, l_up;
   logic [SEL_W-1:0]     s_rd, s_up;
   logic                 g_up_pred, l_up_pred;
   pick_e                pick;

   assign lk_slot = lookup_pc[HI_BIT:LO_BIT];
   assign up_slot = upd_pc[HI_BIT:LO_BIT];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{lookup_pc, upd_pc, s_up};

   // first level of the local side: per-branch histories
   tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_slot), .rd_hist(lk_lhist),
      .up_en(upd_valid), .up_idx(up_slot), .up_bit(upd_taken),
      .up_hist(up_lhist)
   );

   // second level of the local side
   tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lhist), .rd_ctr(l_rd),
      .up_en(upd_valid), .up_idx(up_lhist), .up_inc(upd_taken),
      .up_ctr(l_up)
   );

   // global-history counters
   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_ctr(g_rd),
      .up_en(upd_valid), .up_idx(ghr_q), .up_inc(upd_taken),
      .up_ctr(g_up)
   );

   assign g_up_pred = g_up[GCTR_W-1];
   assign l_up_pred = l_up[LCTR_W-1];

   // chooser: up means trust the local side
   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_ctr(s_rd),
      .up_en(upd_valid && (g_up_pred != l_up_pred)),
      .up_idx(ghr_q), .up_inc(l_up_pred == upd_taken),
      .up_ctr(s_up)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ghr_q <= '0;
      else if (upd_valid) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken};
   end

   assign pick        = pick_e'(s_rd[SEL_W-1]);
   assign pred_global = g_rd[GCTR_W-1];
   assign pred_local  = l_rd[LCTR_W-1];
   assign pred_taken  = (pick == PICK_LOCAL) ? pred_local : pred_global;
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int PC_W    = 32,
   parameter int GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lookup_pc,
   input logic               pred_taken,
   input logic               pred_global,
   input logic               pred_local,
   input logic               upd_valid,
   input logic               upd_taken,
   input logic [GHIST_W-1:0] ghr
);
   assert_hist_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ghr == '0);

   assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ghr[0] == $past(upd_taken));

   assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0]));

   assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghr));

   assert_pred_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(lookup_pc) -> ($stable(pred_taken) &&
                      $stable(pred_global) && $stable(pred_local))));

   assert_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_global == pred_local) |-> (pred_taken == pred_global));
endmodule

bind tournament_predictor tbp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc),
   .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
   .upd_valid(upd_valid), .upd_taken(upd_taken), .ghr(ghr_q)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
   localparam int PW = 8;
   localparam int GH = 3;
   localparam int LI = 2;
   localparam int LH = 3;
   localparam int GN = 1 << GH;
   localparam int LN = 1 << LI;
   localparam int CN = 1 << LH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PW-1:0] lookup_pc = '0;
   logic [PW-1:0] upd_pc = '0;
   logic upd_valid = 1'b0;
   logic upd_taken = 1'b0;
   logic pred_taken, pred_global, pred_local;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   int mg [GN];
   int ms [GN];
   int ml [CN];
   int mh [LN];
   int ghr;

   always #4 clk = ~clk;

   tournament_predictor #(.PC_W(PW), .GHIST_W(GH), .LHT_IDX_W(LI),
                          .LHIST_W(LH)) uut (
      .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc),
      .pred_taken(pred_taken), .pred_global(pred_global),
      .pred_local(pred_local), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic int sat(input int v, input int mx, input bit up);
      if (up) return (v == mx) ? v : v + 1;
      return (v == 0) ? v : v - 1;
   endfunction

   // one lookup (with optional concurrent update), checked against the model
   task automatic step(input int pc, input bit tk, input bit doupd);
      int slot, gp, lp, sp;
      @(negedge clk);
      lookup_pc = PW'(pc);
      upd_pc    = PW'(pc);
      upd_taken = tk;
      upd_valid = doupd;
      #1;
      slot = (pc >> 2) % LN;
      gp = (mg[ghr] >= 2) ? 1 : 0;
      lp = (ml[mh[slot]] >= 4) ? 1 : 0;
      sp = (ms[ghr] >= 2) ? 1 : 0;
      check("R2 R3 R9 global", pred_global, gp[0]);
      check("R4 R5 R6 local", pred_local, lp[0]);
      check("R7 R8 final", pred_taken, sp ? lp[0] : gp[0]);
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      if (doupd) begin
         if (gp != lp) ms[ghr] = sat(ms[ghr], 3, (lp == int'(tk)));
         mg[ghr] = sat(mg[ghr], 3, tk);
         ml[mh[slot]] = sat(ml[mh[slot]], 7, tk);
         mh[slot] = ((mh[slot] << 1) | int'(tk)) % CN;
         ghr = ((ghr << 1) | int'(tk)) % GN;
      end
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < GN; i++) begin mg[i] = 1; ms[i] = 1; end
      for (int i = 0; i < CN; i++) ml[i] = 3;
      for (int i = 0; i < LN; i++) mh[i] = 0;
      ghr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every address predicts not taken after reset, no update
      for (int pc = 0; pc < 64; pc++) begin
         @(negedge clk);
         lookup_pc = PW'(pc);
         #1;
         check("R1 final", pred_taken, 1'b0);
         check("R1 global", pred_global, 1'b0);
         check("R1 local", pred_local, 1'b0);
      end

      // R6: saturate upward then downward on one branch
      for (int i = 0; i < 12; i++) step(16, 1'b1, 1'b1);
      @(negedge clk); lookup_pc = 8'd16; #1;
      check("R6 local saturated taken", pred_local, 1'b1);
      for (int i = 0; i < 12; i++) step(16, 1'b0, 1'b1);
      @(negedge clk); lookup_pc = 8'd16; #1;
      check("R6 local saturated not taken", pred_local, 1'b0);

      // R4: repeating T T N pattern per slot lets the local side learn it
      for (int r = 0; r < 40; r++)
         for (int s = 0; s < LN; s++)
            for (int k = 0; k < 3; k++) step(s * 4, (k != 2), 1'b1);

      // R10: lookups with taken on the update port but upd_valid low
      for (int i = 0; i < 30; i++) step(i * 4, 1'b1, 1'b0);

      // pseudo-random outcomes and addresses, some without update
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(int'(lfsr[7:0]), lfsr[9] | lfsr[11], lfsr[14:12] != 3'd0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule